// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a wide bundle of interrupt source lines and turns them into two processor requests: a normal request and a fast request. Each source owns a small configuration byte made of an enable bit, a type bit and a four-bit priority level. A source that is both enabled and asserted becomes pending. Its type bit decides which of the two requests it competes for. For each request the block registers the number of the winning source, a request strobe and a "nothing pending" flag, and it refreshes them every cycle.

Winners are chosen by priority level first and by source number second. Level 15 is the most urgent and level 0 the least. When two pending sources share a level, the higher-numbered source wins. The normal request also passes through a mask threshold: a normal source only counts when its level is strictly above the threshold. Setting the threshold to 15 therefore silences every normal request. Fast requests ignore the threshold.

Configuration goes through a small register port that has a privilege input. Privileged writes update the configuration. Privileged reads return the stored value one cycle later. A write without privilege is dropped. A read without privilege returns zero and raises an error flag. The read side is a two-state machine. `BUS_IDLE` moves to `BUS_RDRESP` when a read is presented. `BUS_RDRESP` stays in `BUS_RDRESP` on a back-to-back read and otherwise returns to `BUS_IDLE`.

Top module: `prio_int_ctrl`

## Requirements
- R1: A source is pending only while its line is high and its enable bit (bit 0 of its configuration byte) is set; a disabled source never wins.
- R2: The type bit (bit 1 of the configuration byte) sends a pending source to the fast request when set and to the normal request when clear; a source never appears on the other output.
- R3: Among qualifying normal sources, the one with the highest level (bits 7:4 of the configuration byte, 15 highest) wins; on equal levels the higher source number wins.
- R4: Fast sources are arbitrated by the same level-then-number rule, and the mask threshold has no effect on them.
- R5: A normal source qualifies only if its level is strictly greater than the mask threshold (register address 0, bits 3:0); a threshold of 15 blocks all normal requests.
- R6: The winner number, request strobe and none flag of each output are registered and reflect the sources and configuration present one clock edge earlier; with nothing qualifying, the none flag is 1, the strobe 0 and the number 0.
- R7: A privileged write at address 0 sets the threshold, and one at address NUM_SRC+i sets the byte of source i (bits 3:2 read back as 0); a privileged read returns that value with the read-valid strobe one cycle after the request.
- R8: A write issued with the privilege input low changes no register.
- R9: A read issued with the privilege input low returns zero data with the error flag set in its response cycle.
- R10: After reset every source is disabled with type 0 and level 0, the threshold is 0, and both outputs show none pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt source lines, level sensitive |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Privilege of the current access |
| bus_addr | input | SRC_W+1 | Register address: 0 threshold, NUM_SRC+i source i |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Read was refused for lack of privilege |
| irq_req | output | 1 | Normal request |
| irq_id | output | SRC_W | Winning normal source number |
| irq_none | output | 1 | No normal source qualifies |
| fiq_req | output | 1 | Fast request |
| fiq_id | output | SRC_W | Winning fast source number |
| fiq_none | output | 1 | No fast source qualifies |

## Verification
Two things can fall in the same cycle: a privileged configuration write and a change on the source lines. The bench drives both on one edge. It expects the outputs first to reflect the new lines under the old configuration, and only one edge later the new configuration. The fast and normal arbiters also resolve in the same cycle from one source vector. Sweeps across every threshold with mixed patterns check that both winners match the bench's own level-then-number computation at the same time.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LVL_W  = 4;
    localparam int DATA_W = 8;

    typedef logic [LVL_W-1:0] level_t;

    typedef struct packed {
        level_t     lvl;
        logic [1:0] rsvd;
        logic       fast;
        logic       en;
    } src_cfg_t;

    typedef enum logic [0:0] {
        BUS_IDLE   = 1'b0,
        BUS_RDRESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = SRC_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic                           bus_priv,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic                           bus_rvalid,
    output logic                           bus_err,
    output logic [NUM_SRC-1:0]             en_o,
    output logic [NUM_SRC-1:0]             fast_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_o,
    output level_t                         mask_o
);

    src_cfg_t           cfg_q [NUM_SRC];
    level_t             mask_q;
    bus_state_t         state_q, state_d;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q;

    logic [SRC_W-1:0]   idx;
    logic               src_hit, mask_hit, rd_req, wr_ok;
    logic [DATA_W-1:0]  rd_val;

    assign idx      = bus_addr[SRC_W-1:0];
    assign src_hit  = bus_addr[SRC_W] && (int'(idx) < NUM_SRC);
    assign mask_hit = (bus_addr == '0);
    assign rd_req   = bus_sel && !bus_wr;
    assign wr_ok    = bus_sel && bus_wr && bus_priv;

    always_comb begin
        rd_val = '0;
        if (mask_hit)     rd_val = DATA_W'(mask_q);
        else if (src_hit) rd_val = cfg_q[idx];
    end

    // Read-response state machine: next state
    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE:   if (rd_req) state_d = BUS_RDRESP;
            BUS_RDRESP: if (rd_req) state_d = BUS_RDRESP;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Read-response state machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (rd_req) begin
            rdata_q <= bus_priv ? rd_val : '0;
            err_q   <= !bus_priv;
        end
    end

    assign bus_rvalid = (state_q == BUS_RDRESP);
    assign bus_rdata  = bus_rvalid ? rdata_q : '0;
    assign bus_err    = bus_rvalid && err_q;

    // Configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
        end else if (wr_ok) begin
            if (mask_hit)     mask_q     <= bus_wdata[LVL_W-1:0];
            else if (src_hit) cfg_q[idx] <= bus_wdata & 8'hF3;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_out
        assign en_o[g]   = cfg_q[g].en;
        assign fast_o[g] = cfg_q[g].fast;
        assign lvl_o[g]  = cfg_q[g].lvl;
    end
    assign mask_o = mask_q;

    assert_unpriv_wr_ign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_priv) |=> $stable(mask_q));

    assert_unpriv_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && bus_err) |-> (bus_rdata == '0));

    assert_rd_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_SRC  = 128,
    parameter bit USE_MASK = 1'b1,
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            req_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    input  level_t                        thresh_i,
    output logic                          req_o,
    output logic [SRC_W-1:0]              win_id_o,
    output logic                          none_o
);

    logic [NUM_SRC-1:0] qual, qual_d;
    logic               best_any;
    level_t             best_lvl;
    logic [SRC_W-1:0]   best_id;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign qual[g] = req_i[g] && (!USE_MASK || (lvl_i[g] > thresh_i));
    end

    // Level first, then number: ">=" lets a later (higher) index take a tie.
    always_comb begin
        best_any = 1'b0;
        best_lvl = '0;
        best_id  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!best_any || (lvl_i[i] >= best_lvl))) begin
                best_any = 1'b1;
                best_lvl = lvl_i[i];
                best_id  = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_o    <= 1'b0;
            win_id_o <= '0;
            none_o   <= 1'b1;
            qual_d   <= '0;
        end else begin
            req_o    <= best_any;
            win_id_o <= best_id;
            none_o   <= !best_any;
            qual_d   <= qual;
        end
    end

    assert_win_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> qual_d[win_id_o]);

    assert_idle_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |=> none_o);

    assert_none_id_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        none_o |-> (!req_o && (win_id_o == '0)));

endmodule

// File: rtl/prio_int_ctrl.sv
module prio_int_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int ADDR_W = SRC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_priv,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               bus_rvalid,
    output logic               bus_err,
    output logic               irq_req,
    output logic [SRC_W-1:0]   irq_id,
    output logic               irq_none,
    output logic               fiq_req,
    output logic [SRC_W-1:0]   fiq_id,
    output logic               fiq_none
);

    logic [NUM_SRC-1:0]            en, fast, active, fast_reqs, norm_reqs, fast_d;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    level_t                        mask;

    pic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_priv   (bus_priv),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err),
        .en_o       (en),
        .fast_o     (fast),
        .lvl_o      (lvl),
        .mask_o     (mask)
    );

    assign active    = src_i & en;
    assign fast_reqs = active & fast;
    assign norm_reqs = active & ~fast;

    pic_arbiter #(.NUM_SRC(NUM_SRC), .USE_MASK(1'b0)) u_fast_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (fast_reqs),
        .lvl_i    (lvl),
        .thresh_i (mask),
        .req_o    (fiq_req),
        .win_id_o (fiq_id),
        .none_o   (fiq_none)
    );

    pic_arbiter #(.NUM_SRC(NUM_SRC), .USE_MASK(1'b1)) u_norm_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (norm_reqs),
        .lvl_i    (lvl),
        .thresh_i (mask),
        .req_o    (irq_req),
        .win_id_o (irq_id),
        .none_o   (irq_none)
    );

    // Registered copy of the type bits, used to check routing one edge later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fast_d <= '0;
        else        fast_d <= fast;
    end

    assert_fiq_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |-> fast_d[fiq_id]);

    assert_irq_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !fast_d[irq_id]);

    assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'hF) |=> !irq_req);

endmodule

// File: tb/prio_int_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_int_ctrl_tb_top;
    localparam int N  = 16;
    localparam int SW = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src;
    logic          bus_sel, bus_wr, bus_priv;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          bus_rvalid, bus_err;
    logic          irq_req, irq_none, fiq_req, fiq_none;
    logic [SW-1:0] irq_id, fiq_id;

    always #10 clk = ~clk;

    prio_int_ctrl #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .irq_req(irq_req), .irq_id(irq_id), .irq_none(irq_none),
        .fiq_req(fiq_req), .fiq_id(fiq_id), .fiq_none(fiq_none)
    );

    int checks = 0;
    int errors = 0;
    bit tb_en [N];
    bit tb_fast [N];
    int tb_lvl [N];
    int tb_mask;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input int data, input bit priv);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv;
        bus_addr = AW'(addr); bus_wdata = 8'(data);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic bus_read(input int addr, input bit priv,
                            output int data, output int err, output int vld);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_priv = priv; bus_addr = AW'(addr);
        @(negedge clk);
        data = int'(bus_rdata); err = int'(bus_err); vld = int'(bus_rvalid);
        bus_sel = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic set_cfg(input int i, input bit en, input bit fs, input int lv);
        bus_write(N + i, (lv << 4) | (int'(fs) << 1) | int'(en), 1'b1);
        tb_en[i] = en; tb_fast[i] = fs; tb_lvl[i] = lv;
    endtask

    task automatic set_mask(input int m);
        bus_write(0, m, 1'b1);
        tb_mask = m;
    endtask

    task automatic pick(input logic [N-1:0] s, input bit want_fast,
                        output int any, output int id);
        int best;
        best = -1; any = 0; id = 0;
        for (int i = 0; i < N; i++) begin
            if (s[i] && tb_en[i] && (tb_fast[i] == want_fast) &&
                (want_fast || tb_lvl[i] > tb_mask) && tb_lvl[i] >= best) begin
                best = tb_lvl[i]; id = i; any = 1;
            end
        end
    endtask

    task automatic check_out(input string tag, input logic [N-1:0] s);
        int fa, fi, na, ni;
        pick(s, 1'b1, fa, fi);
        pick(s, 1'b0, na, ni);
        chk({tag, " fiq_req"},  int'(fiq_req),  fa);
        chk({tag, " fiq_none"}, int'(fiq_none), 1 - fa);
        chk({tag, " fiq_id"},   int'(fiq_id),   fi);
        chk({tag, " irq_req"},  int'(irq_req),  na);
        chk({tag, " irq_none"}, int'(irq_none), 1 - na);
        chk({tag, " irq_id"},   int'(irq_id),   ni);
    endtask

    task automatic apply(input string tag, input logic [N-1:0] s);
        @(negedge clk); src = s;
        @(negedge clk);
        check_out(tag, s);
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d, e, v;
        logic [N-1:0] s;
        rst_n = 1'b0; src = '1; bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
        bus_addr = '0; bus_wdata = '0; tb_mask = 0;
        for (int i = 0; i < N; i++) begin tb_en[i] = 0; tb_fast[i] = 0; tb_lvl[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R1: reset state, all lines high but nothing enabled
        @(negedge clk);
        check_out("R10_R1 reset", src);
        bus_read(0, 1'b1, d, e, v);
        chk("R10 mask reset", d, 0);
        bus_read(N + 5, 1'b1, d, e, v);
        chk("R10 cfg reset", d, 0);

        // R7: configure and read back every source
        for (int i = 0; i < N; i++)
            set_cfg(i, (i % 3) != 2, (i % 5) == 0, (i * 7) % 16);
        for (int i = 0; i < N; i++) begin
            bus_read(N + i, 1'b1, d, e, v);
            chk("R7 cfg readback", d, (tb_lvl[i] << 4) | (int'(tb_fast[i]) << 1) | int'(tb_en[i]));
            chk("R7 rvalid", v, 1);
        end

        // R1..R6: sweep every threshold with mixed patterns
        for (int m = 0; m < 16; m++) begin
            set_mask(m);
            bus_read(0, 1'b1, d, e, v);
            chk("R7 mask readback", d, m);
            apply("R5_R6 zero", '0);
            apply("R3_R4_R5 all", '1);
            for (int k = 0; k < 24; k++) begin
                s = N'((k * 40503 + m * 2654 + 1) ^ (k << 3));
                apply("R1_R2_R3_R4_R5 sweep", s);
            end
        end

        // R3 / R4: equal levels, ties go to the higher number
        set_mask(0);
        for (int i = 0; i < N; i++) set_cfg(i, 1'b1, (i % 2) == 0, 9);
        for (int i = 0; i < N; i++) apply("R3_R4 single", N'(1) << i);
        apply("R3_R4 tie all", '1);
        apply("R3_R4 tie low", 16'h00F3);
        set_cfg(2, 1'b1, 1'b1, 10);
        set_cfg(5, 1'b1, 1'b0, 10);
        apply("R3_R4 level beats number", '1);
        set_mask(9);
        apply("R4_R5 fast ignores mask", '1);

        // R6: configuration write and source change on the same edge
        @(negedge clk);
        src = 16'h0300;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = 1'b1;
        bus_addr = AW'(N + 8); bus_wdata = 8'hF0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
        check_out("R6 old cfg new lines", src);
        tb_en[8] = 0; tb_fast[8] = 0; tb_lvl[8] = 15;
        @(negedge clk);
        check_out("R6 new cfg", src);

        // R8: unprivileged writes are dropped
        bus_write(0, 3, 1'b0);
        bus_read(0, 1'b1, d, e, v);
        chk("R8 mask kept", d, 9);
        bus_write(N + 5, 8'h00, 1'b0);
        bus_read(N + 5, 1'b1, d, e, v);
        chk("R8 cfg kept", d, 8'hA1);
        set_mask(0);
        apply("R8 outputs after dropped write", 16'h0020);

        // R9: unprivileged read
        bus_read(N + 5, 1'b0, d, e, v);
        chk("R9 data zero", d, 0);
        chk("R9 err", e, 1);
        chk("R9 rvalid", v, 1);
        bus_read(N + 5, 1'b1, d, e, v);
        chk("R9 err clear when privileged", e, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule